// File: doc/BRIEF.md
# Sleep Wake-Up Controller

This block sits beside a small microcontroller core and watches the events that may end sleep mode. It covers eight external pins, split into two ports (A and B) of four pins each, and four internal timeout pulses: a timer, two counters and a watchdog. Each source follows its own rule. Every source that fires leaves a sticky pending flag that software can read, and any event that wakes the core issues a single-cycle request to reset and restart at address zero.

Pin inputs are asynchronous. They pass through a synchronizer chain, and the block finds an edge by comparing two consecutive synchronized samples. Pin A0 can trigger on either edge, chosen by a polarity input. All other pins trigger only on a falling edge. Pin events count only while the sleep flag is high. In sleep, timer and counter timeouts do nothing. The watchdog always forces a reset.

Top module: `wkup_ctrl`

## Requirements
- R1: While reset is held and right after it, `rst_req_o`, `wake_req_o` and every bit of `pend_o` are 0.
- R2: While `sleep_i` is high, pulses on `tmr_to_i`, `cnt1_to_i` or `cnt2_to_i` set no pending bit and raise neither request, whatever their enables are.
- R3: While `sleep_i` is low, a timer, counter-1 or counter-2 timeout whose enable (`wk_en_i` bit 0, 1 or 2) is set sets `pend_o` bit 0, 1 or 2 on the next clock edge without raising `rst_req_o`. With the enable clear, the timeout is ignored.
- R4: A `wdt_to_i` pulse sets `pend_o` bit 3 and raises `rst_req_o` on the next edge, in any mode. `wake_req_o` rises with it only when `sleep_i` is high.
- R5: Pin A0 (`pend_o` bit 4) triggers on a rising edge when `a0_rise_i` is 1 and on a falling edge when it is 0. The opposite edge is ignored.
- R6: Pins A1 to A3 (`pend_o` bits 5 to 7) trigger only on falling edges. Rising edges are ignored.
- R7: Port-B pin j (`pend_o` bit 8+j) triggers only on a falling edge, and only while `pb_en_i` bit j is set.
- R8: `wk_en_i` bit 3 enables pin A0, bit 4 enables pin A1, and bit 5 enables pins A2 and A3 together.
- R9: A pin edge seen while `sleep_i` is low sets no pending bit and raises no request.
- R10: A pin change driven before clock edge E0 makes `rst_req_o` high after edge E2, not before it. The pulse lasts exactly one cycle.
- R11: A pending bit stays set until its `pend_clr_i` bit is 1 on a clock edge. If a set and a clear hit the same bit on the same edge, the set wins.
- R12: Sources that fire on the same edge, or on back-to-back edges, set all of their pending bits but produce only one single-cycle `rst_req_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Core is in sleep mode |
| pa_i | input | 4 | Port-A pins, asynchronous |
| pb_i | input | 4 | Port-B pins, asynchronous |
| tmr_to_i | input | 1 | Timer timeout pulse |
| cnt1_to_i | input | 1 | Counter-1 timeout pulse |
| cnt2_to_i | input | 1 | Counter-2 timeout pulse |
| wdt_to_i | input | 1 | Watchdog timeout pulse |
| wk_en_i | input | 6 | Enables: 0 timer, 1 counter 1, 2 counter 2, 3 pin A0, 4 pin A1, 5 pins A2/A3 |
| pb_en_i | input | 4 | Per-pin enables for port B |
| a0_rise_i | input | 1 | Pin A0 polarity: 1 rising, 0 falling |
| pend_clr_i | input | 12 | Write-one-to-clear strobes for the pending bits |
| wake_req_o | output | 1 | One-cycle wake pulse for an event taken during sleep |
| rst_req_o | output | 1 | One-cycle request to reset and restart at address 0 |
| pend_o | output | 12 | Sticky pending flags (0 timer, 1-2 counters, 3 watchdog, 4-7 port A, 8-11 port B) |

## Verification
The bench builds the block with its defaults: four pins per port and a two-stage synchronizer. With these values the full enable map can be exercised, including the shared enable for pins A2 and A3, and the three-edge latency from a pin change to the reset pulse can be counted exactly. Directed cases cover each edge rule, each gating rule and the same-edge set-versus-clear collision. A seeded random phase then toggles pins, timeouts, enables and the sleep flag, and compares every cycle against a model built from the requirements.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
   // pending-vector bit positions (software decodes these)
   localparam int TMR_BIT  = 0;
   localparam int C1_BIT   = 1;
   localparam int C2_BIT   = 2;
   localparam int WDT_BIT  = 3;
   localparam int PIN_BASE = 4;
   // width of the timeout-enable slice and the port-A enable slice
   localparam int TO_EN_W  = 3;
   localparam int PA_EN_W  = 3;
endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
   parameter int W       = 4,
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] cur,
   output logic [W-1:0] prv
);
   localparam logic [W-1:0] RST_VEC = {W{RST_VAL}};

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wkup_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];
   logic [W-1:0] prv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= RST_VEC;
         prv_q <= RST_VEC;
      end else begin
         stg[0] <= din;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
         prv_q <= stg[STAGES-1];
      end
   end

   assign cur = stg[STAGES-1];
   assign prv = prv_q;
endmodule

// File: rtl/wkup_edge.sv
module wkup_edge #(
   parameter int NA = 4,
   parameter int NB = 4
) (
   input  logic [NA-1:0]    a_cur,
   input  logic [NA-1:0]    a_prv,
   input  logic [NB-1:0]    b_cur,
   input  logic [NB-1:0]    b_prv,
   input  logic [2:0]       a_en,
   input  logic [NB-1:0]    b_en,
   input  logic             a0_rise,
   output logic [NA+NB-1:0] ev
);
   generate
      if (NA < 3) begin : g_bad_na
         $error("wkup_edge: NA must be at least 3");
      end
      if (NB < 1) begin : g_bad_nb
         $error("wkup_edge: NB must be at least 1");
      end

      for (genvar i = 0; i < NA; i++) begin : g_pa
         logic fall_a;
         logic rise_a;
         assign fall_a = a_prv[i] & ~a_cur[i];
         assign rise_a = ~a_prv[i] & a_cur[i];
         if (i == 0) begin : g_sel_edge
            assign ev[i] = a_en[0] & (a0_rise ? rise_a : fall_a);
         end else if (i == 1) begin : g_own_en
            assign ev[i] = a_en[1] & fall_a;
         end else begin : g_shared_en
            assign ev[i] = a_en[2] & fall_a;
         end
      end

      for (genvar j = 0; j < NB; j++) begin : g_pb
         assign ev[NA+j] = b_en[j] & b_prv[j] & ~b_cur[j];
      end
   endgenerate
endmodule

// File: rtl/wkup_event.sv
module wkup_event
   import wkup_pkg::*;
#(
   parameter int NP = 8,
   localparam int PW = PIN_BASE + NP
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sleep_i,
   input  logic               tmr_i,
   input  logic               c1_i,
   input  logic               c2_i,
   input  logic               wdt_i,
   input  logic [TO_EN_W-1:0] to_en,
   input  logic [NP-1:0]      pin_ev,
   input  logic [PW-1:0]      clr_i,
   output logic [PW-1:0]      pend_o,
   output logic               rst_req_o,
   output logic               wake_req_o
);
   logic [PW-1:0] pend_q;
   logic [PW-1:0] set_v;
   logic          rst_q;
   logic          wake_q;
   logic          cause;

   always_comb begin
      set_v                  = '0;
      set_v[TMR_BIT]         = tmr_i & to_en[0] & ~sleep_i;
      set_v[C1_BIT]          = c1_i  & to_en[1] & ~sleep_i;
      set_v[C2_BIT]          = c2_i  & to_en[2] & ~sleep_i;
      set_v[WDT_BIT]         = wdt_i;
      set_v[PIN_BASE +: NP]  = pin_ev & {NP{sleep_i}};
      cause                  = wdt_i | (sleep_i & (|pin_ev));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         rst_q  <= 1'b0;
         wake_q <= 1'b0;
      end else begin
         pend_q <= (pend_q & ~clr_i) | set_v;
         rst_q  <= cause & ~rst_q;
         wake_q <= cause & sleep_i & ~rst_q;
      end
   end

   assign pend_o     = pend_q;
   assign rst_req_o  = rst_q;
   assign wake_req_o = wake_q;

   // timer timeout during sleep never creates a pending flag
   assert_sleep_timer_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i && tmr_i && !pend_q[TMR_BIT]) |=> !pend_q[TMR_BIT]);

   // watchdog pulse always leads to a reset request unless one is already out
   assert_wdt_forces_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_i && !rst_q) |=> (rst_q && pend_q[WDT_BIT]));

   // a wake pulse never appears without the reset pulse
   assert_wake_with_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wake_q |-> rst_q);

   // uncleared pending bits survive the next edge
   assert_pend_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q & ~clr_i) != '0) |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i)));

   // the reset request is never longer than one cycle
   assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |=> !rst_q);
endmodule

// File: rtl/wkup_ctrl.sv
module wkup_ctrl
   import wkup_pkg::*;
#(
   parameter int NA          = 4,
   parameter int NB          = 4,
   parameter int SYNC_STAGES = 2,
   localparam int NP         = NA + NB,
   localparam int PW         = PIN_BASE + NP
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sleep_i,
   input  logic [NA-1:0] pa_i,
   input  logic [NB-1:0] pb_i,
   input  logic          tmr_to_i,
   input  logic          cnt1_to_i,
   input  logic          cnt2_to_i,
   input  logic          wdt_to_i,
   input  logic [5:0]    wk_en_i,
   input  logic [NB-1:0] pb_en_i,
   input  logic          a0_rise_i,
   input  logic [PW-1:0] pend_clr_i,
   output logic          wake_req_o,
   output logic          rst_req_o,
   output logic [PW-1:0] pend_o
);
   logic [NA-1:0] a_cur, a_prv;
   logic [NB-1:0] b_cur, b_prv;
   logic [NP-1:0] pin_ev;

   wkup_sync #(.W(NA), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_a (
      .clk(clk), .rst_n(rst_n), .din(pa_i), .cur(a_cur), .prv(a_prv));

   wkup_sync #(.W(NB), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_b (
      .clk(clk), .rst_n(rst_n), .din(pb_i), .cur(b_cur), .prv(b_prv));

   wkup_edge #(.NA(NA), .NB(NB)) u_edge (
      .a_cur(a_cur), .a_prv(a_prv), .b_cur(b_cur), .b_prv(b_prv),
      .a_en(wk_en_i[5:3]), .b_en(pb_en_i), .a0_rise(a0_rise_i), .ev(pin_ev));

   wkup_event #(.NP(NP)) u_event (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i),
      .tmr_i(tmr_to_i), .c1_i(cnt1_to_i), .c2_i(cnt2_to_i), .wdt_i(wdt_to_i),
      .to_en(wk_en_i[2:0]), .pin_ev(pin_ev), .clr_i(pend_clr_i),
      .pend_o(pend_o), .rst_req_o(rst_req_o), .wake_req_o(wake_req_o));

   // out of sleep there is never a wake pulse on the following cycle
   assert_awake_no_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_i |=> !wake_req_o);
endmodule

// File: tb/tb_wkup_ctrl.sv
module tb_wkup_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sleep = 1'b0;
   logic [3:0]  pa = 4'hF, pb = 4'hF;
   logic        tmr = 1'b0, c1 = 1'b0, c2 = 1'b0, wdt = 1'b0;
   logic [5:0]  wk_en = 6'h3F;
   logic [3:0]  pb_en = 4'hF;
   logic        a0r = 1'b0;
   logic [11:0] clr = '0;
   logic        wake, rreq;
   logic [11:0] pend;
   int          checks = 0, fails = 0;

   always #5 clk = ~clk;

   wkup_ctrl dut (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep), .pa_i(pa), .pb_i(pb),
      .tmr_to_i(tmr), .cnt1_to_i(c1), .cnt2_to_i(c2), .wdt_to_i(wdt),
      .wk_en_i(wk_en), .pb_en_i(pb_en), .a0_rise_i(a0r), .pend_clr_i(clr),
      .wake_req_o(wake), .rst_req_o(rreq), .pend_o(pend));

   // expected pin events from the requirements (R5 R6 R7 R8)
   function automatic logic [7:0] exp_pin(input logic [7:0] cur, input logic [7:0] prv,
                                          input logic [5:0] en, input logic [3:0] ben,
                                          input logic rise0);
      logic [7:0] f, r, e;
      f = prv & ~cur;
      r = ~prv & cur;
      e[0] = en[3] & (rise0 ? r[0] : f[0]);
      e[1] = en[4] & f[1];
      e[2] = en[5] & f[2];
      e[3] = en[5] & f[3];
      e[7:4] = ben & f[7:4];
      return e;
   endfunction

   logic [7:0]  m_s1, m_s2, m_pv;
   logic [11:0] m_pend;
   logic        m_rst, m_wake;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= 8'hFF; m_s2 <= 8'hFF; m_pv <= 8'hFF;
         m_pend <= '0; m_rst <= 1'b0; m_wake <= 1'b0;
      end else begin
         logic [7:0]  pe;
         logic [11:0] st;
         logic        cause;
         pe = exp_pin(m_s2, m_pv, wk_en, pb_en, a0r);
         st = {pe & {8{sleep}}, wdt, c2 & wk_en[2] & ~sleep,
               c1 & wk_en[1] & ~sleep, tmr & wk_en[0] & ~sleep};
         cause = wdt | (sleep & (|pe));
         m_s1 <= {pb, pa}; m_s2 <= m_s1; m_pv <= m_s2;
         m_pend <= (m_pend & ~clr) | st;
         m_rst  <= cause & ~m_rst;
         m_wake <= cause & sleep & ~m_rst;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_all();
      clr = '1; step(1); clr = '0;
   endtask

   // drive pins, confirm nothing appears early, stop at the cycle the pulse should show
   task automatic pins(input logic [3:0] a, input logic [3:0] b, input string tag);
      pa = a; pb = b;
      step(2);
      chk({tag, " early"}, {31'd0, rreq}, 32'd0);
      step(1);
   endtask

   initial begin
      #2_000_000;
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'h5EED_0042);
      step(3);
      chk("R1 reset pend", {20'd0, pend}, 32'd0);
      chk("R1 reset req", {30'd0, rreq, wake}, 32'd0);
      rst_n = 1'b1;
      step(1);
      chk("R1 after reset", {18'd0, rreq, wake, pend}, 32'd0);

      // R2
      sleep = 1'b1; tmr = 1; c1 = 1; c2 = 1; step(1);
      tmr = 0; c1 = 0; c2 = 0;
      chk("R2 sleep timeouts", {18'd0, rreq, wake, pend}, 32'd0);

      // R3
      sleep = 1'b0; wk_en = 6'b111101; tmr = 1; c1 = 1; step(1);
      tmr = 0; c1 = 0;
      chk("R3 enabled timer", {20'd0, pend}, 32'h001);
      chk("R3 no reset", {31'd0, rreq}, 32'd0);
      wk_en = 6'h3F; clear_all();
      chk("R11 cleared", {20'd0, pend}, 32'd0);

      // R4 awake then asleep
      wdt = 1; step(1); wdt = 0;
      chk("R4 wdt awake", {18'd0, rreq, wake, pend}, {18'd0, 2'b10, 12'h008});
      step(1);
      chk("R10 pulse width", {31'd0, rreq}, 32'd0);
      clear_all();
      sleep = 1'b1; wdt = 1; step(1); wdt = 0;
      chk("R4 wdt asleep", {30'd0, rreq, wake}, 32'd3);
      step(1); clear_all();

      // R6 + R10
      pins(4'b1101, 4'hF, "R10 A1");
      chk("R10 A1 fall", {19'd0, rreq, pend}, {19'd0, 1'b1, 12'h020});
      step(1);
      chk("R10 one cycle", {31'd0, rreq}, 32'd0);
      pins(4'hF, 4'hF, "R6 A1 rise");
      chk("R6 rise ignored", {19'd0, rreq, pend}, {19'd0, 1'b0, 12'h020});
      clear_all();

      // R5
      a0r = 1'b1;
      pins(4'b1110, 4'hF, "R5 fall");
      chk("R5 fall ignored in rise mode", {19'd0, rreq, pend}, 32'd0);
      pins(4'hF, 4'hF, "R5 rise");
      chk("R5 rise taken", {19'd0, rreq, pend}, {19'd0, 1'b1, 12'h010});
      clear_all(); a0r = 1'b0;
      pins(4'b1110, 4'hF, "R5 fall2");
      chk("R5 fall taken", {19'd0, rreq, pend}, {19'd0, 1'b1, 12'h010});
      clear_all();
      pins(4'hF, 4'hF, "R5 rise2");
      chk("R5 rise ignored in fall mode", {19'd0, rreq, pend}, 32'd0);

      // R7
      pb_en = 4'b1101;
      pins(4'hF, 4'b1101, "R7 b1");
      chk("R7 disabled pin", {19'd0, rreq, pend}, 32'd0);
      pins(4'hF, 4'b1001, "R7 b2");
      chk("R7 enabled pin", {19'd0, rreq, pend}, {19'd0, 1'b1, 12'h400});
      pins(4'hF, 4'hF, "R7 rise");
      clear_all(); pb_en = 4'hF;

      // R8
      wk_en = 6'b011111;
      pins(4'b0011, 4'hF, "R8 a23 off");
      chk("R8 shared enable off", {19'd0, rreq, pend}, 32'd0);
      pins(4'hF, 4'hF, "R8 restore");
      wk_en = 6'b101111;
      pins(4'b1101, 4'hF, "R8 a1 off");
      chk("R8 A1 enable off", {19'd0, rreq, pend}, 32'd0);
      pins(4'b0101, 4'hF, "R8 a3 on");
      chk("R8 A3 shared on", {19'd0, rreq, pend}, {19'd0, 1'b1, 12'h080});
      pins(4'hF, 4'hF, "R8 restore2");
      clear_all(); wk_en = 6'h3F;

      // R9
      sleep = 1'b0;
      pins(4'hF, 4'b1110, "R9 awake");
      chk("R9 awake pin ignored", {18'd0, rreq, wake, pend}, 32'd0);
      pins(4'hF, 4'hF, "R9 restore");
      sleep = 1'b1;

      // R11 set wins over clear
      wdt = 1; clr = 12'h008; step(1); wdt = 0; clr = 12'h001;
      chk("R11 set beats clear", {20'd0, pend}, 32'h008);
      step(1); clr = '0;
      chk("R11 other clear no effect", {20'd0, pend}, 32'h008);
      clear_all();

      // R12
      pins(4'b1101, 4'b0111, "R12 pair");
      chk("R12 both pending", {19'd0, rreq, pend}, {19'd0, 1'b1, 12'h820});
      step(1);
      chk("R12 single pulse", {31'd0, rreq}, 32'd0);
      pins(4'hF, 4'hF, "R12 restore");
      wdt = 1; step(1);
      chk("R12 back-to-back first", {31'd0, rreq}, 32'd1);
      step(1); wdt = 0;
      chk("R12 back-to-back merged", {31'd0, rreq}, 32'd0);
      clear_all();

      // random phase against the requirement model
      for (int n = 0; n < 3000; n++) begin
         chk("R12 random model pend", {20'd0, pend}, {20'd0, m_pend});
         chk("R10 random model req", {30'd0, rreq, wake}, {30'd0, m_rst, m_wake});
         if ($urandom_range(63) == 0) sleep = ~sleep;
         if ($urandom_range(63) == 0) begin
            wk_en = 6'($urandom); pb_en = 4'($urandom); a0r = 1'($urandom);
         end
         for (int p = 0; p < 4; p++) begin
            if ($urandom_range(7) == 0) pa[p] = ~pa[p];
            if ($urandom_range(7) == 0) pb[p] = ~pb[p];
         end
         tmr = ($urandom_range(15) == 0);
         c1  = ($urandom_range(15) == 0);
         c2  = ($urandom_range(15) == 0);
         wdt = ($urandom_range(31) == 0);
         clr = ($urandom_range(7) == 0) ? 12'($urandom) : 12'h0;
         step(1);
      end

      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule